// File: doc/BRIEF.md
# Self-Timed Program and Erase Controller

This block sits behind the serial front end of a small nonvolatile word store. The front end decodes an instruction and, when chip select drops after a complete instruction, pulses a commit strobe. The request bus carries an operation code, an address, a data word and the organisation mode. The controller holds a write-enable latch that gates every modifying operation. It times a fixed-length internal program cycle from its own clock counter, raises a busy flag for the whole cycle, and applies the change to a register-file storage array. A combinational read port is available at all times.

The storage holds 256 words of 16 bits. In byte mode the address gains one bit: bit 0 picks the byte lane and the upper eight bits pick the word. Every write overwrites its target directly, so no separate erase is needed before it. An erased location reads as all ones.

Top module: `prog_erase_ctrl`

## Requirements
- R1: After reset busy is low, the write-enable latch is clear, and every location reads as all ones.
- R2: Op code 5 sets the write-enable latch and op code 6 clears it. While the latch is clear, a modifying request (op codes 1 to 4) leaves busy low and leaves storage unchanged.
- R3: The read port returns stored data whatever the state of the write-enable latch.
- R4: An accepted modifying request raises busy on the clock edge that samples the commit strobe. Busy then stays high for exactly PROG_CYCLES cycles with no further input activity.
- R5: Storage changes on the edge where busy falls. Reads during the cycle return the old contents.
- R6: Op code 1 (write word) replaces the addressed contents with the data, with no erase needed beforehand.
- R7: Op code 2 (erase word) sets the addressed contents to all ones. Op code 3 (erase all) sets every word to 16'hFFFF.
- R8: Op code 4 (write all) stores the same data in every word.
- R9: A commit that arrives while busy is high is ignored, including op codes 5 and 6.
- R10: When wide_mode is 0 (byte mode), the word index is addr[8:1]. addr[0]=1 selects bits 15:8 and addr[0]=0 selects bits 7:0. A read returns the byte in rd_data[7:0] with zeros above. Write and erase touch only the selected byte. Write all puts data[7:0] into both bytes of every word.
- R11: Op codes 0 and 7 have no effect on busy, the latch or storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| req_commit | input | 1 | One-cycle strobe: chip select fell after a complete instruction |
| req_op | input | 3 | Decoded operation code |
| req_addr | input | 9 | Request address (bit 8 used only in byte mode) |
| req_data | input | 16 | Request data (low byte used in byte mode) |
| rd_addr | input | 9 | Read address |
| rd_data | output | 16 | Read data |
| busy | output | 1 | High while a program cycle runs |

## Verification
The hardest situation to reach is a second commit that lands inside a running program cycle. It must leave both the storage and the latch alone, and the latch itself has no port. The stimulus starts a write, then issues a second write and a disable request partway through the busy window. Once the cycle ends, it shows that the second address is untouched. It then shows that the latch is still set by running a further write that does raise busy. Byte-lane handling is reached by mixing byte-mode writes to both lanes of one word and then reading that word back in word mode.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_WRITE = 3'd1,
        OP_ERASE = 3'd2,
        OP_ERALL = 3'd3,
        OP_WRALL = 3'd4,
        OP_WEN   = 3'd5,
        OP_WDIS  = 3'd6,
        OP_RSVD  = 3'd7
    } pe_op_e;

    function automatic logic is_modify(input logic [2:0] op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_ERALL) || (op == OP_WRALL);
    endfunction
endpackage

// File: rtl/pe_wen_latch.sv
module pe_wen_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    output logic wen
);
    typedef struct packed {
        logic wen;
    } wl_state_t;

    wl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en)      st_d.wen = 1'b0;
        else if (set_en) st_d.wen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wen = st_q.wen;
endmodule

// File: rtl/pe_cycle_timer.sv
module pe_cycle_timer #(
    parameter int CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tm_state_t;

    tm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                done      = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.cnt < CW'(CYCLES)));
endmodule

// File: rtl/pe_word_store.sv
module pe_word_store
    import pe_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int WIDTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [2:0]           upd_op,
    input  logic [$clog2(WORDS):0] upd_addr,
    input  logic [WIDTH-1:0]     upd_data,
    input  logic                 upd_wide,
    input  logic                 rd_wide,
    input  logic [$clog2(WORDS):0] rd_addr,
    output logic [WIDTH-1:0]     rd_data
);
    localparam int AW = $clog2(WORDS);
    localparam int HW = WIDTH / 2;

    logic [WIDTH-1:0] mem_q [WORDS];
    logic [WIDTH-1:0] mem_d [WORDS];

    logic [AW-1:0]    upd_idx;
    logic [WIDTH-1:0] lane_mask;
    logic [WIDTH-1:0] put_val;

    always_comb begin
        if (upd_wide) begin
            upd_idx   = upd_addr[AW-1:0];
            lane_mask = '1;
            put_val   = upd_data;
        end else begin
            upd_idx   = upd_addr[AW:1];
            lane_mask = upd_addr[0] ? {{HW{1'b1}}, {HW{1'b0}}}
                                    : {{HW{1'b0}}, {HW{1'b1}}};
            put_val   = {upd_data[HW-1:0], upd_data[HW-1:0]};
        end
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic hit;
        assign hit = (upd_idx == AW'(w));

        always_comb begin
            mem_d[w] = mem_q[w];
            if (upd_en) begin
                unique case (upd_op)
                    OP_WRITE: if (hit) mem_d[w] = (mem_q[w] & ~lane_mask) | (put_val & lane_mask);
                    OP_ERASE: if (hit) mem_d[w] = mem_q[w] | lane_mask;
                    OP_ERALL: mem_d[w] = '1;
                    OP_WRALL: mem_d[w] = put_val;
                    default:  mem_d[w] = mem_q[w];
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[w] <= '1;
            else        mem_q[w] <= mem_d[w];
        end
    end

    logic [WIDTH-1:0] rd_word;
    always_comb begin
        if (rd_wide) begin
            rd_word = mem_q[rd_addr[AW-1:0]];
            rd_data = rd_word;
        end else begin
            rd_word = mem_q[rd_addr[AW:1]];
            rd_data = {{HW{1'b0}}, (rd_addr[0] ? rd_word[WIDTH-1:HW] : rd_word[HW-1:0])};
        end
    end
endmodule

// File: rtl/prog_erase_ctrl.sv
module prog_erase_ctrl
    import pe_pkg::*;
#(
    parameter int PROG_CYCLES = 200000,
    parameter int WORDS       = 256,
    parameter int WIDTH       = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wide_mode,
    input  logic                   req_commit,
    input  logic [2:0]             req_op,
    input  logic [$clog2(WORDS):0] req_addr,
    input  logic [WIDTH-1:0]       req_data,
    input  logic [$clog2(WORDS):0] rd_addr,
    output logic [WIDTH-1:0]       rd_data,
    output logic                   busy
);
    localparam int AW = $clog2(WORDS) + 1;

    typedef struct packed {
        logic [2:0]       op;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] data;
        logic             wide;
    } pend_t;

    pend_t pend_d, pend_q;
    logic  accept, start, set_wen, clr_wen, wen_q, done;

    always_comb begin
        accept  = req_commit && !busy;
        set_wen = accept && (req_op == OP_WEN);
        clr_wen = accept && (req_op == OP_WDIS);
        start   = accept && is_modify(req_op) && wen_q;
        pend_d  = pend_q;
        if (start) begin
            pend_d.op   = req_op;
            pend_d.addr = req_addr;
            pend_d.data = req_data;
            pend_d.wide = wide_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    pe_wen_latch i_wen (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (set_wen),
        .clr_en (clr_wen),
        .wen    (wen_q)
    );

    pe_cycle_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    pe_word_store #(.WORDS(WORDS), .WIDTH(WIDTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (done),
        .upd_op   (pend_q.op),
        .upd_addr (pend_q.addr),
        .upd_data (pend_q.data),
        .upd_wide (pend_q.wide),
        .rd_wide  (wide_mode),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    // busy only rises after a commit seen with the latch set
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(req_commit) && $past(wen_q)));

    assert_busy_ignores_wen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_commit && busy) |=> $stable(wen_q));

    assert_rsvd_no_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_commit && !busy && (req_op == OP_NONE || req_op == OP_RSVD)) |=> !busy);
endmodule

// File: tb/test_prog_erase_ctrl.sv
module test_prog_erase_ctrl;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b1;
    logic        req_commit = 1'b0;
    logic [2:0]  req_op = '0;
    logic [8:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic [8:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        busy;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    prog_erase_ctrl #(.PROG_CYCLES(N)) i_prog_erase_ctrl (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .req_commit(req_commit), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_check(input logic wide, input logic [8:0] a, input logic [15:0] exp, input string tag);
        wide_mode = wide;
        rd_addr   = a;
        #1;
        check(rd_data == exp, tag, rd_data, exp);
        wide_mode = 1'b1;
    endtask

    // drive a commit at a negedge; returns at the following negedge
    task automatic commit(input logic wide, input logic [2:0] op, input logic [8:0] a, input logic [15:0] d);
        @(negedge clk);
        wide_mode = wide; req_op = op; req_addr = a; req_data = d; req_commit = 1'b1;
        @(negedge clk);
        req_commit = 1'b0; wide_mode = 1'b1;
    endtask

    // accepted modifying request: check busy length, old data during the cycle
    task automatic run_prog(input logic wide, input logic [2:0] op, input logic [8:0] a,
                            input logic [15:0] d, input logic [8:0] watch, input logic [15:0] old_val);
        int cyc;
        commit(wide, op, a, d);
        check(busy == 1'b1, "R4 busy rises", busy, 1);
        rd_check(1'b1, watch, old_val, "R5 old data while busy");
        cyc = 1;
        while (busy && cyc < 10*N) begin
            @(negedge clk);
            if (busy) cyc++;
        end
        check(cyc == N, "R4 busy length", cyc, N);
    endtask

    task automatic t_reset;
        check(busy == 1'b0, "R1 busy at reset", busy, 0);
        rd_check(1'b1, 9'd0, 16'hFFFF, "R1 word 0 erased");
        rd_check(1'b1, 9'd255, 16'hFFFF, "R1 word 255 erased");
    endtask

    task automatic t_locked;
        commit(1'b1, 3'd1, 9'd5, 16'h1234);
        check(busy == 1'b0, "R2 locked write no busy", busy, 0);
        repeat (N+2) @(negedge clk);
        rd_check(1'b1, 9'd5, 16'hFFFF, "R1 R2 locked write ignored");
    endtask

    task automatic t_write;
        commit(1'b1, 3'd5, 9'd0, 16'h0);
        check(busy == 1'b0, "R2 enable has no cycle", busy, 0);
        run_prog(1'b1, 3'd1, 9'd5, 16'h1234, 9'd5, 16'hFFFF);
        rd_check(1'b1, 9'd5, 16'h1234, "R6 write word");
        run_prog(1'b1, 3'd1, 9'd5, 16'hABCD, 9'd5, 16'h1234);
        rd_check(1'b1, 9'd5, 16'hABCD, "R6 overwrite without erase");
        rd_check(1'b1, 9'd6, 16'hFFFF, "R6 neighbour untouched");
    endtask

    task automatic t_erase;
        run_prog(1'b1, 3'd1, 9'd6, 16'h0F0F, 9'd6, 16'hFFFF);
        run_prog(1'b1, 3'd2, 9'd5, 16'h0000, 9'd5, 16'hABCD);
        rd_check(1'b1, 9'd5, 16'hFFFF, "R7 erase word");
        rd_check(1'b1, 9'd6, 16'h0F0F, "R7 erase leaves neighbour");
    endtask

    task automatic t_busy_ignore;
        commit(1'b1, 3'd1, 9'd10, 16'h1010);
        repeat (3) @(negedge clk);
        commit(1'b1, 3'd1, 9'd11, 16'h1111);
        commit(1'b1, 3'd6, 9'd0, 16'h0);
        while (busy) @(negedge clk);
        rd_check(1'b1, 9'd10, 16'h1010, "R9 first write done");
        rd_check(1'b1, 9'd11, 16'hFFFF, "R9 write during busy ignored");
        run_prog(1'b1, 3'd1, 9'd11, 16'h2222, 9'd11, 16'hFFFF);
        rd_check(1'b1, 9'd11, 16'h2222, "R9 disable during busy ignored");
    endtask

    task automatic t_wral_eral;
        run_prog(1'b1, 3'd4, 9'd0, 16'h5A5A, 9'd0, 16'hFFFF);
        rd_check(1'b1, 9'd0, 16'h5A5A, "R8 write all word 0");
        rd_check(1'b1, 9'd128, 16'h5A5A, "R8 write all word 128");
        rd_check(1'b1, 9'd255, 16'h5A5A, "R8 write all word 255");
        run_prog(1'b1, 3'd3, 9'd0, 16'h0, 9'd128, 16'h5A5A);
        rd_check(1'b1, 9'd0, 16'hFFFF, "R7 erase all word 0");
        rd_check(1'b1, 9'd200, 16'hFFFF, "R7 erase all word 200");
    endtask

    task automatic t_byte;
        run_prog(1'b0, 3'd1, 9'd9, 16'hAA77, 9'd4, 16'hFFFF);
        run_prog(1'b0, 3'd1, 9'd8, 16'hBB11, 9'd4, 16'h77FF);
        rd_check(1'b0, 9'd9, 16'h0077, "R10 byte read high lane");
        rd_check(1'b0, 9'd8, 16'h0011, "R10 byte read low lane");
        rd_check(1'b1, 9'd4, 16'h7711, "R10 lane placement in word");
        run_prog(1'b0, 3'd2, 9'd9, 16'h0, 9'd4, 16'h7711);
        rd_check(1'b1, 9'd4, 16'hFF11, "R10 byte erase keeps other lane");
        run_prog(1'b0, 3'd4, 9'd0, 16'h993C, 9'd4, 16'hFF11);
        rd_check(1'b1, 9'd0, 16'h3C3C, "R10 byte write all replicates");
        rd_check(1'b1, 9'd255, 16'h3C3C, "R10 byte write all last word");
    endtask

    task automatic t_undef;
        commit(1'b1, 3'd0, 9'd0, 16'h0000);
        check(busy == 1'b0, "R11 op 0 no busy", busy, 0);
        commit(1'b1, 3'd7, 9'd0, 16'h0000);
        check(busy == 1'b0, "R11 op 7 no busy", busy, 0);
        rd_check(1'b1, 9'd0, 16'h3C3C, "R11 storage unchanged");
        run_prog(1'b1, 3'd1, 9'd1, 16'h4444, 9'd1, 16'h3C3C);
        rd_check(1'b1, 9'd1, 16'h4444, "R11 latch still set");
    endtask

    task automatic t_disable;
        commit(1'b1, 3'd6, 9'd0, 16'h0);
        commit(1'b1, 3'd1, 9'd1, 16'h0000);
        check(busy == 1'b0, "R2 disabled write no busy", busy, 0);
        repeat (N+2) @(negedge clk);
        rd_check(1'b1, 9'd1, 16'h4444, "R2 R3 read while disabled");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_locked();
        t_write();
        t_erase();
        t_busy_ignore();
        t_wral_eral();
        t_byte();
        t_undef();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule